// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a synchronous serial master that a processor drives through a small register bus. Software sets the frame length, clock polarity, clock phase and bit-clock divider, then turns the port on and writes words into the data register. Each word waits in an eight-entry transmit queue. The shift engine takes the words in order and sends each one most significant bit first on the data-out line. During the same frame it captures the data-in line, and it places the received frame in an eight-entry receive queue. Software reads that queue through the same data register.

The bit clock is derived from the system clock in two stages: an even prescale value from 2 to 254, and a rate field from 0 to 255. One bit lasts prescale × (1 + rate) system clocks, and each half of the bit clock lasts half of that. A status register reports the fill state of both queues and whether the engine still has work. Chip select is handled outside the block.

Top module: `spim_core`

## Requirements
- R1: After reset, control 0 (offset 0x00) reads 0x0007, control 1 (0x04) reads 0x0000, prescale (0x10) reads 0x0002 and status (0x0C) reads 0x0003.
- R2: A write to prescale stores the low eight data bits with bit 0 forced to 0. A stored result below 2 becomes 2.
- R3: Each half period of the serial clock lasts (prescale/2) × (1 + rate) system clocks. The rate field is bits 15:8 of control 0.
- R4: The serial clock rests at the polarity bit (control 0 bit 6) and makes two edges per bit. With phase (control 0 bit 7) at 0, data-in is sampled on the first edge of each bit. With phase at 1, it is sampled on the second edge.
- R5: The frame length is control 0 bits 3:0 plus one. Frames go out most significant bit first, taken from the low bits of the written word; unused upper bits are ignored. Received frames are right-justified with the upper bits at zero.
- R6: While control 1 bit 1 (enable) is 0, no frame starts and the serial clock makes no edge. Queued words stay in the transmit queue.
- R7: Status bit 0 is transmit-empty, bit 1 transmit-not-full, bit 2 receive-not-empty, bit 3 receive-full and bit 4 busy. All other bits read 0.
- R8: A data write while the transmit queue holds eight words is dropped.
- R9: A data read while the receive queue is empty returns 0 and changes nothing.
- R10: A frame that completes while the receive queue holds eight words is discarded. The queue contents stay as they were.
- R11: Busy is 1 while a frame is shifting, or while the port is enabled and the transmit queue is not empty. Busy returns to 0 once the last frame is done.
- R12: Every transmitted frame produces exactly one received frame, and received frames are read back in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the access |
| sclk_o | output | 1 | Serial bit clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench builds the block with its default queue depth of eight and a word width of sixteen. At these values it can fill both queues and push past them, so the dropped-write path and the discarded-frame path are both reachable. Prescale values of 2, 6 and 254 combine with rate values of 0 to 2. Together they cover the shortest bit clock (one system clock per half period), a non-trivial product of the two divider stages, and a slow frame long enough to observe busy while the frame is still in progress. Frame lengths of 4, 8 and 16 bits and all four polarity and phase combinations are run against a bench-side serial responder.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 5;
    localparam int PSC_W  = 8;
    localparam int RATE_W = 8;
    localparam int LEN_W  = 4;
    localparam int HALF_W = PSC_W - 1 + RATE_W + 1;

    localparam logic [ADDR_W-1:0] OFS_CFG  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_PSC  = 5'h10;

    localparam int ENABLE_BIT = 1;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              cpha;
        logic              cpol;
        logic [LEN_W-1:0]  len_m1;
    } frame_cfg_t;

    typedef struct packed {
        frame_cfg_t       cfg;
        logic             en;
        logic [PSC_W-1:0] psc;
    } regs_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = st_q.wp + AW'(1);
        end
        if (do_pop) begin
            st_d.rp = st_q.rp + AW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign count = st_q.cnt;
endmodule

// File: rtl/spim_rate.sv
module spim_rate
    import spim_pkg::*;
(
    input  logic [PSC_W-1:0]  psc_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic [HALF_W-1:0] half_o
);
    logic [HALF_W-1:0] psc_half;
    logic [HALF_W-1:0] rate_p1;

    always_comb begin
        psc_half = HALF_W'(psc_i[PSC_W-1:1]);
        rate_p1  = HALF_W'({1'b0, rate_i} + (RATE_W + 1)'(1));
        half_o   = psc_half * rate_p1;
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int FW = WORD_W,
    parameter int LW = LEN_W,
    parameter int HW = HALF_W,
    localparam int EW = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [FW-1:0] word_i,
    input  logic          cpol_i,
    input  logic          cpha_i,
    input  logic [LW-1:0] len_m1_i,
    input  logic [HW-1:0] half_i,
    input  logic          miso_i,
    output logic          active_o,
    output logic          done_o,
    output logic [FW-1:0] rx_word_o,
    output logic          sclk_o,
    output logic          mosi_o
);
    typedef struct packed {
        logic          active;
        logic          cpha;
        logic [LW-1:0] len_m1;
        logic [HW-1:0] half;
        logic [HW-1:0] cnt;
        logic [EW-1:0] edge_idx;
        logic [FW-1:0] tx_sh;
        logic [FW-1:0] rx_sh;
        logic          sclk;
        logic          mosi;
    } sh_st_t;

    sh_st_t s_d, s_q;
    logic [EW-1:0] last_edge;
    logic [LW-1:0] shamt;
    logic          samp_edge;

    always_comb begin
        s_d       = s_q;
        done_o    = 1'b0;
        last_edge = {s_q.len_m1, 1'b1};
        shamt     = LW'(FW - 1) - len_m1_i;
        samp_edge = (s_q.edge_idx[0] == s_q.cpha);
        if (!s_q.active) begin
            s_d.sclk = cpol_i;
            if (start_i) begin
                s_d.active   = 1'b1;
                s_d.cpha     = cpha_i;
                s_d.len_m1   = len_m1_i;
                s_d.half     = half_i;
                s_d.cnt      = '0;
                s_d.edge_idx = '0;
                s_d.rx_sh    = '0;
                s_d.tx_sh    = word_i << shamt;
                if (!cpha_i) begin
                    s_d.mosi  = s_d.tx_sh[FW-1];
                    s_d.tx_sh = s_d.tx_sh << 1;
                end
            end
        end else if (s_q.cnt == s_q.half - HW'(1)) begin
            s_d.cnt      = '0;
            s_d.sclk     = ~s_q.sclk;
            s_d.edge_idx = s_q.edge_idx + EW'(1);
            if (samp_edge) begin
                s_d.rx_sh = {s_q.rx_sh[FW-2:0], miso_i};
            end else if (s_q.cpha || (s_q.edge_idx != last_edge)) begin
                s_d.mosi  = s_q.tx_sh[FW-1];
                s_d.tx_sh = s_q.tx_sh << 1;
            end
            if (s_q.edge_idx == last_edge) begin
                s_d.active = 1'b0;
                done_o     = 1'b1;
            end
        end else begin
            s_d.cnt = s_q.cnt + HW'(1);
        end
        rx_word_o = s_d.rx_sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = s_q.active;
    assign sclk_o   = s_q.sclk;
    assign mosi_o   = s_q.mosi;
endmodule

// File: rtl/spim_core.sv
module spim_core
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    regs_t regs_d, regs_q;

    logic              wr_stb, rd_stb;
    logic              tx_push, tx_pop, tx_empty, tx_full;
    logic              rx_push, rx_pop, rx_empty, rx_full;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic [HALF_W-1:0] half;
    logic              active, sh_done, start, busy;
    logic [PSC_W-1:0]  psc_wr;

    assign wr_stb = bus_sel && bus_wr;
    assign rd_stb = bus_sel && !bus_wr;

    always_comb begin
        regs_d = regs_q;
        psc_wr = bus_wdata[PSC_W-1:0] & ~PSC_W'(1);
        if (psc_wr < PSC_W'(2)) psc_wr = PSC_W'(2);
        if (wr_stb) begin
            case (bus_addr)
                OFS_CFG: begin
                    regs_d.cfg.rate   = bus_wdata[15:8];
                    regs_d.cfg.cpha   = bus_wdata[7];
                    regs_d.cfg.cpol   = bus_wdata[6];
                    regs_d.cfg.len_m1 = bus_wdata[LEN_W-1:0];
                end
                OFS_CTL: regs_d.en  = bus_wdata[ENABLE_BIT];
                OFS_PSC: regs_d.psc = psc_wr;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q            <= '0;
            regs_q.cfg.len_m1 <= LEN_W'(7);
            regs_q.psc        <= PSC_W'(2);
        end else begin
            regs_q <= regs_d;
        end
    end

    assign start   = regs_q.en && !tx_empty && !active;
    assign tx_pop  = start;
    assign tx_push = wr_stb && (bus_addr == OFS_DATA) && !tx_full;
    assign rx_pop  = rd_stb && (bus_addr == OFS_DATA) && !rx_empty;
    assign rx_push = sh_done && !rx_full;
    assign busy    = active || (regs_q.en && !tx_empty);

    always_comb begin
        case (bus_addr)
            OFS_CFG:  bus_rdata = {regs_q.cfg.rate, regs_q.cfg.cpha, regs_q.cfg.cpol,
                                   2'b00, regs_q.cfg.len_m1};
            OFS_CTL:  bus_rdata = WORD_W'({regs_q.en, 1'b0});
            OFS_DATA: bus_rdata = rx_empty ? '0 : rx_head;
            OFS_STAT: bus_rdata = WORD_W'({busy, rx_full, !rx_empty, !tx_full, tx_empty});
            OFS_PSC:  bus_rdata = WORD_W'(regs_q.psc);
            default:  bus_rdata = '0;
        endcase
    end

    spim_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
        .wdata(bus_wdata), .rdata(tx_head), .empty(tx_empty), .full(tx_full),
        .count(tx_cnt)
    );

    spim_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
        .wdata(rx_word), .rdata(rx_head), .empty(rx_empty), .full(rx_full),
        .count(rx_cnt)
    );

    spim_rate u_rate (
        .psc_i(regs_q.psc), .rate_i(regs_q.cfg.rate), .half_o(half)
    );

    spim_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start_i(start), .word_i(tx_head),
        .cpol_i(regs_q.cfg.cpol), .cpha_i(regs_q.cfg.cpha),
        .len_m1_i(regs_q.cfg.len_m1), .half_i(half), .miso_i(miso_i),
        .active_o(active), .done_o(sh_done), .rx_word_o(rx_word),
        .sclk_o(sclk_o), .mosi_o(mosi_o)
    );
endmodule

// File: rtl/spim_core_chk.sv
module spim_core_chk #(
    parameter int DEPTH = 8,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          active,
    input logic          sclk,
    input logic          cpol,
    input logic          done,
    input logic          rx_pop,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [7:0]    psc
);
    a_r6_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !active) |=> !active);

    a_r11_prompt_start: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tx_cnt != '0 && !active) |=> active);

    a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> (sclk == $past(cpol)));

    a_r8_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH));

    a_r12_rx_push: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_cnt < CW'(DEPTH) && !rx_pop) |=> (rx_cnt == $past(rx_cnt) + CW'(1)));

    a_r10_rx_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_cnt == CW'(DEPTH) && !rx_pop) |=> (rx_cnt == CW'(DEPTH)));

    a_r2_psc_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (psc[0] == 1'b0) && (psc >= 8'd2));
endmodule

bind spim_core spim_core_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(regs_q.en), .active(active), .sclk(sclk_o),
    .cpol(regs_q.cfg.cpol), .done(sh_done), .rx_pop(rx_pop),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .psc(regs_q.psc)
);

// File: tb/spim_core_bench.sv
module spim_core_bench;
    import spim_pkg::*;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    wire  [15:0] rdata;
    wire         sclk, mosi;
    logic        miso;

    always #(CLK_NS/2) clk = ~clk;

    spim_core u_spim_core (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .sclk_o(sclk), .mosi_o(mosi),
        .miso_i(miso)
    );

    int n_chk = 0, n_bad = 0;
    logic        mon_on = 1'b0;
    int          blen = 8, nsamp = 0, fidx = 0, edges = 0;
    logic        bcpol = 1'b0, bcpha = 1'b0;
    logic [15:0] acc = '0;
    logic [15:0] slv [16];
    logic [15:0] cap [16];

    task automatic take_sample();
        acc = {acc[14:0], mosi};
        nsamp++;
        if (nsamp == blen) begin
            if (fidx < 16) cap[fidx] = acc;
            fidx++;
            nsamp = 0;
            acc = '0;
        end
    endtask

    always @(posedge sclk) if (mon_on) begin edges++; if (bcpol == bcpha) take_sample(); end
    always @(negedge sclk) if (mon_on) begin edges++; if (bcpol != bcpha) take_sample(); end

    always_comb begin
        miso = 1'b0;
        if (mon_on && fidx < 16 && nsamp < blen) miso = slv[fidx][blen-1-nsamp];
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [15:0] d);
        @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [15:0] d);
        @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk); sel = 1'b0;
    endtask

    task automatic setup(logic [7:0] rate, logic pol, logic pha, int len);
        mon_on = 1'b0;
        bcpol = pol; bcpha = pha; blen = len;
        bus_write(OFS_CFG, {rate, pha, pol, 2'b00, 4'(len - 1)});
        repeat (3) @(negedge clk);
        fidx = 0; nsamp = 0; acc = '0; edges = 0;
        mon_on = 1'b1;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        int guard = 0;
        do begin
            bus_read(OFS_STAT, s);
            guard++;
        end while (s[4] && guard < 20000);
        if (s[4]) chk("R11 busy never cleared", s, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        bus_read(OFS_CFG, v);  chk("R1 cfg reset", v, 16'h0007);
        bus_read(OFS_CTL, v);  chk("R1 ctl reset", v, 16'h0000);
        bus_read(OFS_PSC, v);  chk("R1 prescale reset", v, 16'h0002);
        bus_read(OFS_STAT, v); chk("R1 R7 status reset", v, 16'h0003);
        bus_read(OFS_DATA, v); chk("R9 empty read", v, 16'h0000);
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        bus_write(OFS_PSC, 16'h0005); bus_read(OFS_PSC, v); chk("R2 odd cleared", v, 16'h0004);
        bus_write(OFS_PSC, 16'h0001); bus_read(OFS_PSC, v); chk("R2 floor from 1", v, 16'h0002);
        bus_write(OFS_PSC, 16'h0000); bus_read(OFS_PSC, v); chk("R2 floor from 0", v, 16'h0002);
        bus_write(OFS_PSC, 16'hABFF); bus_read(OFS_PSC, v); chk("R2 top value", v, 16'h00FE);
        bus_write(OFS_PSC, 16'h0002);
    endtask

    task automatic t_disabled();
        logic [15:0] v;
        bus_write(OFS_CTL, 16'h0000);
        setup(8'd0, 1'b0, 1'b0, 8);
        slv[0] = 16'h00C5;
        bus_write(OFS_DATA, 16'h003C);
        repeat (60) @(negedge clk);
        chk("R6 no edges while off", 16'(edges), 16'd0);
        bus_read(OFS_STAT, v); chk("R6 R7 R11 status while off", v, 16'h0002);
        bus_write(OFS_CTL, 16'h0002);
        wait_idle();
        chk("R6 frame after enable", cap[0], 16'h003C);
        bus_read(OFS_DATA, v); chk("R12 rx after enable", v, 16'h00C5);
        bus_read(OFS_STAT, v); chk("R7 status idle", v, 16'h0003);
    endtask

    task automatic t_modes();
        logic [15:0] v;
        for (int m = 0; m < 4; m++) begin
            setup(8'd1, m[1], m[0], 8);
            slv[0] = 16'(8'h5A ^ (m * 8'h11));
            bus_write(OFS_DATA, 16'(8'h93 + m * 8'h21));
            wait_idle();
            chk("R4 R5 mosi frame", cap[0], 16'(8'h93 + m * 8'h21));
            bus_read(OFS_DATA, v); chk("R4 R12 rx frame", v, 16'(8'h5A ^ (m * 8'h11)));
            chk("R4 two edges per bit", 16'(edges), 16'd16);
            chk("R4 idle level", 16'(sclk), 16'(m[1]));
        end
    endtask

    task automatic t_lengths();
        logic [15:0] v;
        setup(8'd0, 1'b0, 1'b0, 16);
        slv[0] = 16'h5AC3;
        bus_write(OFS_DATA, 16'hA53C);
        wait_idle();
        chk("R5 16-bit out", cap[0], 16'hA53C);
        bus_read(OFS_DATA, v); chk("R5 16-bit in", v, 16'h5AC3);
        setup(8'd0, 1'b0, 1'b1, 4);
        slv[0] = 16'h0009;
        bus_write(OFS_DATA, 16'hFFF6);
        wait_idle();
        chk("R5 4-bit out low bits", cap[0], 16'h0006);
        bus_read(OFS_DATA, v); chk("R5 4-bit in right-justified", v, 16'h0009);
        chk("R5 4-bit edge count", 16'(edges), 16'd8);
    endtask

    task automatic t_divider();
        longint t1, t2, t3;
        bus_write(OFS_PSC, 16'h0006);
        setup(8'd2, 1'b0, 1'b0, 8);
        slv[0] = 16'h0000;
        bus_write(OFS_DATA, 16'h0081);
        @(sclk); t1 = $time;
        @(sclk); t2 = $time;
        @(sclk); t3 = $time;
        chk("R3 half period a", 16'((t2 - t1) / CLK_NS), 16'd9);
        chk("R3 half period b", 16'((t3 - t2) / CLK_NS), 16'd9);
        wait_idle();
        chk("R3 frame intact", cap[0], 16'h0081);
        begin logic [15:0] v; bus_read(OFS_DATA, v); end
    endtask

    task automatic t_busy();
        logic [15:0] v;
        bus_write(OFS_PSC, 16'h00FE);
        setup(8'd0, 1'b1, 1'b0, 8);
        slv[0] = 16'h0042;
        bus_write(OFS_DATA, 16'h0024);
        bus_read(OFS_STAT, v); chk("R11 busy at start", 16'(v[4]), 16'd1);
        repeat (300) @(negedge clk);
        bus_read(OFS_STAT, v); chk("R11 busy mid frame", v, 16'h0013);
        wait_idle();
        bus_read(OFS_STAT, v); chk("R11 busy cleared", v, 16'h0007);
        bus_read(OFS_DATA, v); chk("R12 slow frame rx", v, 16'h0042);
        bus_write(OFS_PSC, 16'h0002);
    endtask

    task automatic t_queues();
        logic [15:0] v;
        bus_write(OFS_CTL, 16'h0000);
        setup(8'd0, 1'b0, 1'b0, 8);
        for (int i = 0; i < 9; i++) begin
            slv[i] = 16'(8'hE0 + i);
            bus_write(OFS_DATA, 16'(8'h10 + i));
        end
        bus_read(OFS_STAT, v); chk("R7 R8 tx full status", v, 16'h0000);
        bus_write(OFS_CTL, 16'h0002);
        wait_idle();
        chk("R8 ninth write dropped", 16'(fidx), 16'd8);
        for (int i = 0; i < 8; i++) chk("R8 R12 sent order", cap[i], 16'(8'h10 + i));
        bus_read(OFS_STAT, v); chk("R7 R10 rx full status", v, 16'h000F);
        bus_write(OFS_DATA, 16'h0099);
        wait_idle();
        chk("R10 extra frame sent", cap[8], 16'h0099);
        bus_read(OFS_STAT, v); chk("R10 still full", v, 16'h000F);
        for (int i = 0; i < 8; i++) begin
            bus_read(OFS_DATA, v); chk("R10 R12 rx order", v, 16'(8'hE0 + i));
        end
        bus_read(OFS_DATA, v); chk("R9 R10 empty after drain", v, 16'h0000);
        bus_read(OFS_STAT, v); chk("R7 final status", v, 16'h0003);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin slv[i] = '0; cap[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prescale();
        t_disabled();
        t_modes();
        t_lengths();
        t_divider();
        t_busy();
        t_queues();
        report();
    end
endmodule